// File: doc/BRIEF.md
# Broadcast-Step Vector Sum Array

This block is a small data-parallel array. It has N processing elements that share one sequencing controller. Each element owns a single W-bit accumulator register. Software first writes one operand into each element through an indexed load port. It then pulses `start` and chooses one of two pairing orders. From then on the controller issues exactly one broadcast add step per clock. In each step the same add is applied in every element that the controller marks active for that step. An active element adds the register of the element a fixed distance to its right (the step's stride) into its own register. All other elements hold their value.

After log2(N) steps element 0 holds the wrapped sum of all N operands, and the block raises a one-cycle completion pulse. The sum leaves the block on a registered output that holds its value between completions. Partial sums are left in place in the other elements. A second reduction run without reloading therefore folds those leftovers together. This makes the pairing pattern, and the elements that were left untouched, visible at the ports.

Top module: `vec_tree_sum`

## Requirements
- R1: A synchronous active-high reset clears every element register, `busy`, `done` and `sum` to zero.
- R2: While `busy` is low, `load_en` writes `load_data` into the element selected by `load_idx` at the clock edge. While `busy` is high, a load is ignored and leaves the element unchanged.
- R3: A `start` seen at a clock edge while `busy` is low latches `order_sel` and raises `busy` for exactly log2(N) cycles. One add step is performed per busy cycle.
- R4: With `order_sel` = 0 (widening strides), step k (k = 0, 1, ...) uses stride 2^k. The active elements are those whose index is a multiple of 2^(k+1). For N=8 this gives {0,2,4,6} add +1, then {0,4} add +2, then {0} adds +4.
- R5: With `order_sel` = 1 (narrowing strides), step k uses stride N/2^(k+1), and the active elements are those with index below the stride. For N=8 this gives {0..3} add +4, then {0,1} add +2, then {0} adds +1.
- R6: An element that is not active in a step keeps its register value through that step.
- R7: Every addition is taken modulo 2^W.
- R8: `done` is high for exactly one cycle, in the cycle after the final step edge. At that moment `sum` equals element 0's final register value. `sum` changes at no other time.
- R9: A `start` that arrives while `busy` is high is ignored, including one in the cycle of the final step. A `start` in the `done` cycle is accepted.
- R10: Changes on `order_sel` while `busy` is high have no effect on the running reduction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write one operand into an element |
| load_idx | input | log2(N) | Target element of the write |
| load_data | input | W | Operand value |
| start | input | 1 | Begin a reduction |
| order_sel | input | 1 | 0 = widening strides, 1 = narrowing strides |
| busy | output | 1 | Reduction steps in progress |
| done | output | 1 | One-cycle completion pulse |
| sum | output | W | Registered total of the last reduction |

## Verification
Several events can fall in one cycle. The final add step can coincide with a fresh `start`, and that start must be dropped. The completion pulse can coincide with a new `start`, and that start must launch a new run without disturbing the held `sum`. An operand load can share an edge with `start` while idle, and the loaded value must then take part in the reduction. The bench drives each of these pairs on the same negative clock phase. A bench-side model of the element registers then judges each case through the resulting `sum` and `busy`. Follow-up runs without reloading expose any stray write or any wrong active set.

// File: rtl/vts_pkg.sv
package vts_pkg;
  typedef enum logic {
    ORD_WIDEN  = 1'b0,
    ORD_NARROW = 1'b1
  } order_e;
endpackage

// File: rtl/vts_pe.sv
module vts_pe #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         act,
  input  logic [W-1:0] partner,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (wr_en)
      acc <= wr_data;
    else if (act)
      acc <= acc + partner;   // wraps at W bits
  end
endmodule

// File: rtl/vts_ctrl.sv
module vts_ctrl
  import vts_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         order_in,
  output logic         busy,
  output logic         done,
  output logic         last,
  output logic [N-1:0] act,
  output logic [IW:0]  stride
);
  localparam int LAST_STEP = IW - 1;

  order_e        ord_q;
  logic [IW-1:0] step_q;
  int            stride_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step_q <= '0;
      ord_q  <= ORD_WIDEN;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          step_q <= '0;
          ord_q  <= order_e'(order_in);
        end
      end else if (step_q == IW'(LAST_STEP)) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (ord_q == ORD_WIDEN)
      stride_i = 1 << int'(step_q);
    else
      stride_i = N >> (int'(step_q) + 1);
  end

  assign stride = (IW+1)'(stride_i);
  assign last   = busy && (step_q == IW'(LAST_STEP));

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (ord_q == ORD_WIDEN)
        act[i] = busy && ((i & (2 * stride_i - 1)) == 0);
      else
        act[i] = busy && (i < stride_i);
    end
  end
endmodule

// File: rtl/vec_tree_sum.sv
module vec_tree_sum #(
  parameter int N  = 8,
  parameter int W  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [IW-1:0] load_idx,
  input  logic [W-1:0]  load_data,
  input  logic          start,
  input  logic          order_sel,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  sum
);
  logic [N-1:0] act;
  logic [IW:0]  stride;
  logic         last;
  logic [W-1:0] acc     [N];
  logic [W-1:0] partner [N];
  logic [W-1:0] sum_q;

  vts_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .order_in (order_sel),
    .busy     (busy),
    .done     (done),
    .last     (last),
    .act      (act),
    .stride   (stride)
  );

  // partner routing: element i sees element i+stride (zero past the end)
  always_comb begin
    for (int i = 0; i < N; i++) begin
      partner[i] = '0;
      for (int j = 0; j < N; j++)
        if (j == i + int'(stride))
          partner[i] = acc[j];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pe
    vts_pe #(.W(W)) u_pe (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (load_en && !busy && (load_idx == IW'(g))),
      .wr_data (load_data),
      .act     (act[g]),
      .partner (partner[g]),
      .acc     (acc[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      sum_q <= '0;
    else if (last)
      sum_q <= acc[0] + partner[0];
  end

  assign sum = sum_q;
endmodule

// File: rtl/vts_checker.sv
module vts_checker #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] sum
);
  localparam int STEPS = $clog2(N);
  localparam int CW    = $clog2(N) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      run_cnt <= '0;
    else if (busy)
      run_cnt <= run_cnt + 1'b1;
    else
      run_cnt <= '0;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                   // R8
  AST_SUM_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sum));                           // R8
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == CW'(STEPS)));                 // R3
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));                             // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < CW'(STEPS)));                  // R9
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));                     // R3
endmodule

bind vec_tree_sum vts_checker #(.N(N), .W(W)) u_vts_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .sum   (sum)
);

// File: tb/vec_tree_sum_test.sv
`timescale 1ns/1ps
module vec_tree_sum_test;
  localparam int N   = 8;
  localparam int W   = 16;
  localparam int IW  = 3;
  localparam int LOG = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [IW-1:0] load_idx = '0;
  logic [W-1:0]  load_data = '0;
  logic          start = 1'b0;
  logic          order_sel = 1'b0;
  logic          busy, done;
  logic [W-1:0]  sum;

  int vecs  = 0;
  int fails = 0;
  logic [W-1:0] m [N];

  always #10 clk = ~clk;

  vec_tree_sum #(.N(N), .W(W)) uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_idx(load_idx),
    .load_data(load_data), .start(start), .order_sel(order_sel),
    .busy(busy), .done(done), .sum(sum)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // bench model of the element registers, built from R4/R5/R6/R7
  task automatic model_reduce(input bit ord);
    logic [W-1:0] nxt [N];
    for (int k = 0; k < LOG; k++) begin
      int s;
      s = ord ? (N >> (k + 1)) : (1 << k);
      for (int i = 0; i < N; i++) begin
        bit a;
        a = ord ? (i < s) : ((i % (2 * s)) == 0);
        nxt[i] = a ? W'(m[i] + m[i + s]) : m[i];
      end
      for (int i = 0; i < N; i++) m[i] = nxt[i];
    end
  endtask

  task automatic load_one(input int idx, input logic [W-1:0] v);
    load_en = 1'b1; load_idx = IW'(idx); load_data = v;
    @(negedge clk);
    load_en = 1'b0;
    m[idx] = v;
  endtask

  task automatic kick(input bit ord);
    start = 1'b1; order_sel = ord;
  endtask

  // entry at a negedge with start already driven; pre=1 means the start edge has passed
  task automatic run(input string tag, input bit ord, input bit poke, input bit pre,
                     input bit chain, input bit nord);
    logic [W-1:0] exp;
    model_reduce(ord);
    exp = m[0];
    if (!pre) begin
      @(negedge clk);
      start = 1'b0;
      chk("R3 busy after start", W'(busy), 1);
      chk("R8 no done while busy", W'(done), 0);
    end
    for (int k = 1; k < LOG; k++) begin
      if (poke) begin
        load_en = 1'b1; load_idx = 1; load_data = 16'hFFFF;   // R2 ignored while busy
        order_sel = ~order_sel;                                // R10
      end
      @(negedge clk);
      load_en = 1'b0;
      chk("R3 busy mid run", W'(busy), 1);
      chk("R8 done low mid run", W'(done), 0);
    end
    if (poke) begin
      start = 1'b1; order_sel = ~order_sel;                    // R9 start at final step
    end
    @(negedge clk);
    start = 1'b0;
    chk("R8 done pulse", W'(done), 1);
    chk("R3 busy ends", W'(busy), 0);
    chk(tag, sum, exp);
    if (chain) kick(nord);                                     // R9 start in done cycle
    @(negedge clk);
    start = 1'b0;
    chk("R8 done single cycle", W'(done), 0);
    chk("R8 sum held", sum, exp);
    chk(chain ? "R9 start in done cycle accepted" : "R9 no restart", W'(busy), W'(chain));
  endtask

  task automatic t_reset;
    chk("R1 busy reset", W'(busy), 0);
    chk("R1 done reset", W'(done), 0);
    chk("R1 sum reset", sum, 0);
    kick(0);
    run("R1 elements cleared", 0, 0, 0, 0, 0);
  endtask

  task automatic t_widen;
    for (int i = 0; i < N; i++) load_one(i, W'(i + 1));
    kick(0);
    run("R4 widening sum", 0, 0, 0, 0, 0);
    chk("R4 total 36", sum, 16'd36);
    kick(0);
    run("R6 widening rerun", 0, 0, 0, 0, 0);
  endtask

  task automatic t_narrow;
    for (int i = 0; i < N; i++) load_one(i, W'((i + 1) * (i + 3)));
    kick(1);
    run("R5 narrowing sum", 1, 0, 0, 0, 0);
    kick(1);
    run("R6 narrowing rerun", 1, 0, 0, 0, 0);
    kick(0);
    run("R6 cross-order rerun", 0, 0, 0, 0, 0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < N; i++) load_one(i, 16'hF000);
    kick(1);
    run("R7 wrapped sum", 1, 0, 0, 0, 0);
    chk("R7 0x8000", sum, 16'h8000);
  endtask

  task automatic t_poke;
    for (int i = 0; i < N; i++) load_one(i, W'(3 * i + 5));
    kick(0);
    run("R10 order held", 0, 1, 0, 0, 0);
    kick(0);
    run("R2 busy load ignored", 0, 0, 0, 0, 0);
  endtask

  task automatic t_chain;
    for (int i = 0; i < N; i++) load_one(i, W'(i * 7 + 1));
    load_en = 1'b1; load_idx = 3; load_data = 16'h0100;       // load with start, same edge
    m[3] = 16'h0100;
    kick(1);
    @(negedge clk);
    load_en = 1'b0; start = 1'b0;
    chk("R3 busy after start", W'(busy), 1);
    run("R2 load with start", 1, 0, 1, 1, 0);
    run("R9 chained run", 0, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_widen();
    t_narrow();
    t_wrap();
    t_poke();
    t_chain();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule